// File: doc/BRIEF.md
# Output-Stationary Transposed-Convolution Tile Engine

This block produces one square output tile of a transposed (fractionally strided) convolution layer. Instead of scattering each input pixel into overlapping output regions, it walks the output space directly: for each kernel position it steps the output row and column counters by the stride, adds a precomputed per-kernel-index phase offset, and derives the single input pixel that feeds that output. Every accumulator therefore receives each contribution in place, and no overlap buffer is needed.

A single valid/ready input stream carries, per tile, one bias word followed by every input channel's data. Each channel consists of an input patch and a kernel. After each channel is loaded, the engine runs one fixed-point multiply-accumulate per cycle and skips all-zero kernel taps outright. Once the last channel is done, the finished tile leaves on a valid/ready output stream in one pass. The next tile is accepted only after that pass completes. Fetching data from memory, address generation for external buffers and writing results back are done by neighbouring blocks.

Top module: `deconv_cu`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A tile arrives on the input stream as one bias word, then for each of NCH channels (default 2) the TIN×TIN input patch in row-major order (TIN = ceil(TOUT/STRIDE) + ceil(KSZ/STRIDE), default 4) followed by the KSZ×KSZ kernel in row-major order (default 3×3).
- R3: Every output pixel starts at the bias word, so a tile whose kernels are all zero returns the bias in every pixel.
- R4: Output pixel (oh, ow) equals the bias plus, for every channel and kernel tap (kh, kw) with oh = ih·STRIDE + kh − PAD and ow = iw·STRIDE + kw − PAD for a patch pixel (ih, iw) inside the patch, the rescaled product of that tap and that pixel (defaults STRIDE=2, PAD=1, TOUT=4).
- R5: Data words are signed two's complement with FRAC_W fractional bits (default 32-bit words, 16 fractional bits). Each product is rescaled by an arithmetic right shift of FRAC_W bits, which rounds toward minus infinity.
- R6: Each accumulate saturates to 0x7FFFFFFF on positive overflow and to 0x80000000 on negative overflow instead of wrapping.
- R7: After the last kernel word of a channel is taken, `in_ready` stays low for exactly 1 + ceil(TOUT/STRIDE)² × (number of nonzero taps) cycles, default 1 + 4·n. Zero taps cost no cycles.
- R8: Contributions reach each accumulator in order of channel, then kernel row, then kernel column, so saturation in an earlier channel is visible in the final value.
- R9: The finished tile leaves as TOUT×TOUT words in row-major order. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold.
- R10: `in_ready` is low from the end of loading the last channel until the last output word is taken. It is high in the cycle after that handshake, so input offered earlier is not consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Engine can take an input word |
| in_data | input | DATA_W | Bias, patch or kernel word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream takes the output pixel |
| out_data | output | DATA_W | Output pixel, row-major |

## Verification
Most internal faults reach the ports only when the tile drains. A wrong phase offset, patch index, loop bound or saturation bound shows up as wrong pixel values, and only after every channel of that tile has finished, so each pixel of a finished tile is compared with an independently built scatter-form model. A wrong zero-skip search or a loop counter that stops at the wrong value shows up earlier, as a wrong number of cycles with `in_ready` low after the first channel. A fault in the drain sequencing shows up within one cycle as a word out of order, a word that changes under back-pressure, or input accepted too early.

// File: rtl/deconv_pkg.sv
package deconv_pkg;

    typedef enum logic [2:0] {
        ST_BIAS,
        ST_LOAD,
        ST_SEEK,
        ST_MAC,
        ST_DRAIN
    } dcu_state_e;

    // Width of a counter that must hold values 0..n-1 (at least one bit).
    function automatic int cbits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // Non-negative remainder.
    function automatic int pos_mod(input int a, input int m);
        int r;
        r = a % m;
        if (r < 0) r = r + m;
        return r;
    endfunction

    // Phase of the first output index that a kernel tap k reaches exactly.
    function automatic int tap_phase(input int k, input int s, input int p);
        return pos_mod(s - pos_mod(p - k, s), s);
    endfunction

    function automatic int patch_dim(input int tout, input int k, input int s);
        return ceil_div(tout, s) + ceil_div(k, s);
    endfunction

endpackage

// File: rtl/dcu_tile_store.sv
module dcu_tile_store
    import deconv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NIN    = 16,
    parameter int NW     = 9,
    localparam int NLD   = NIN + NW,
    localparam int LW    = cbits(NLD),
    localparam int IAW   = cbits(NIN),
    localparam int WAW   = cbits(NW)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IAW-1:0]    x_addr,
    output logic [DATA_W-1:0] x_data,
    input  logic [WAW-1:0]    w_sel,
    output logic [DATA_W-1:0] w_data,
    output logic [NW-1:0]     nz_mask
);

    logic [DATA_W-1:0] patch_q [NIN];
    logic [DATA_W-1:0] tap_q   [NW];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < LW'(NIN))) begin
            patch_q[IAW'(wr_addr)] <= wr_data;
        end
    end

    for (genvar g = 0; g < NW; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst) begin
                tap_q[g] <= '0;
            end else if (wr_en && (wr_addr == LW'(NIN + g))) begin
                tap_q[g] <= wr_data;
            end
        end
        assign nz_mask[g] = |tap_q[g];
    end

    assign x_data = patch_q[x_addr];
    assign w_data = tap_q[w_sel];

endmodule

// File: rtl/dcu_loop_ctrl.sv
module dcu_loop_ctrl
    import deconv_pkg::*;
#(
    parameter int KSZ    = 3,
    parameter int STRIDE = 2,
    parameter int PAD    = 1,
    parameter int TOUT   = 4,
    parameter int NCH    = 2,
    localparam int TIN   = patch_dim(TOUT, KSZ, STRIDE),
    localparam int NIN   = TIN * TIN,
    localparam int NW    = KSZ * KSZ,
    localparam int NLD   = NIN + NW,
    localparam int NOUT  = TOUT * TOUT,
    localparam int STEPS = ceil_div(TOUT, STRIDE),
    localparam int LW    = cbits(NLD),
    localparam int IAW   = cbits(NIN),
    localparam int WAW   = cbits(NW),
    localparam int AW    = cbits(NOUT),
    localparam int SW    = cbits(STEPS),
    localparam int CHW   = cbits(NCH),
    localparam int KW    = cbits(KSZ)
)(
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    output logic           in_ready,
    output logic           out_valid,
    input  logic           out_ready,
    input  logic [NW-1:0]  nz_mask,
    output logic           bias_load,
    output logic           ld_en,
    output logic [LW-1:0]  ld_addr,
    output logic [WAW-1:0] w_sel,
    output logic [IAW-1:0] x_addr,
    output logic           mac_fire,
    output logic [AW-1:0]  acc_addr,
    output logic [AW-1:0]  rd_addr
);

    dcu_state_e     state;
    logic [LW-1:0]  ld_cnt;
    logic [CHW-1:0] ch;
    logic [WAW-1:0] kidx;
    logic [SW-1:0]  sh, sw;
    logic [AW-1:0]  oidx;

    // Cached phase offsets, one per kernel index.
    int phase_tab [KSZ];
    for (genvar g = 0; g < KSZ; g++) begin : g_phase
        assign phase_tab[g] = tap_phase(g, STRIDE, PAD);
    end

    // Zero-skip search: first nonzero tap, and next nonzero tap after kidx.
    logic           first_ok, next_ok;
    logic [WAW-1:0] first_idx, next_idx;
    always_comb begin
        first_ok  = 1'b0;
        first_idx = '0;
        next_ok   = 1'b0;
        next_idx  = '0;
        for (int j = NW - 1; j >= 0; j--) begin
            if (nz_mask[j]) begin
                first_ok  = 1'b1;
                first_idx = WAW'(j);
            end
            if (nz_mask[j] && (WAW'(j) > kidx)) begin
                next_ok  = 1'b1;
                next_idx = WAW'(j);
            end
        end
    end

    // Output index and dependent patch index for the current step.
    logic [KW-1:0] kh, kw;
    int oh_i, ow_i, nh_i, nw_i, ih_i, iw_i;
    logic in_window;
    always_comb begin
        kh   = KW'(kidx / WAW'(KSZ));
        kw   = KW'(kidx % WAW'(KSZ));
        oh_i = int'(sh) * STRIDE + phase_tab[kh];
        ow_i = int'(sw) * STRIDE + phase_tab[kw];
        nh_i = oh_i + PAD - int'(kh);
        nw_i = ow_i + PAD - int'(kw);
        ih_i = nh_i / STRIDE;
        iw_i = nw_i / STRIDE;
        in_window = (oh_i < TOUT) && (ow_i < TOUT) &&
                    (nh_i >= 0) && (nw_i >= 0) &&
                    (ih_i < TIN) && (iw_i < TIN);
    end

    logic last_step_w, last_step_h, last_ch;
    assign last_step_w = (sw == SW'(STEPS - 1));
    assign last_step_h = (sh == SW'(STEPS - 1));
    assign last_ch     = (ch == CHW'(NCH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_BIAS;
            ld_cnt <= '0;
            ch     <= '0;
            kidx   <= '0;
            sh     <= '0;
            sw     <= '0;
            oidx   <= '0;
        end else begin
            unique case (state)
                ST_BIAS: begin
                    if (in_valid) begin
                        state  <= ST_LOAD;
                        ld_cnt <= '0;
                        ch     <= '0;
                    end
                end
                ST_LOAD: begin
                    if (in_valid) begin
                        if (ld_cnt == LW'(NLD - 1)) begin
                            ld_cnt <= '0;
                            state  <= ST_SEEK;
                        end else begin
                            ld_cnt <= ld_cnt + LW'(1);
                        end
                    end
                end
                ST_SEEK: begin
                    sh <= '0;
                    sw <= '0;
                    if (first_ok) begin
                        kidx  <= first_idx;
                        state <= ST_MAC;
                    end else if (last_ch) begin
                        oidx  <= '0;
                        state <= ST_DRAIN;
                    end else begin
                        ch    <= ch + CHW'(1);
                        state <= ST_LOAD;
                    end
                end
                ST_MAC: begin
                    if (!last_step_w) begin
                        sw <= sw + SW'(1);
                    end else begin
                        sw <= '0;
                        if (!last_step_h) begin
                            sh <= sh + SW'(1);
                        end else begin
                            sh <= '0;
                            if (next_ok) begin
                                kidx <= next_idx;
                            end else if (last_ch) begin
                                oidx  <= '0;
                                state <= ST_DRAIN;
                            end else begin
                                ch    <= ch + CHW'(1);
                                state <= ST_LOAD;
                            end
                        end
                    end
                end
                ST_DRAIN: begin
                    if (out_ready) begin
                        if (oidx == AW'(NOUT - 1)) begin
                            oidx  <= '0;
                            state <= ST_BIAS;
                        end else begin
                            oidx <= oidx + AW'(1);
                        end
                    end
                end
                default: state <= ST_BIAS;
            endcase
        end
    end

    assign in_ready  = (state == ST_BIAS) || (state == ST_LOAD);
    assign out_valid = (state == ST_DRAIN);
    assign bias_load = (state == ST_BIAS) && in_valid;
    assign ld_en     = (state == ST_LOAD) && in_valid;
    assign ld_addr   = ld_cnt;
    assign w_sel     = kidx;
    assign x_addr    = IAW'(ih_i * TIN + iw_i);
    assign acc_addr  = AW'(oh_i * TOUT + ow_i);
    assign mac_fire  = (state == ST_MAC) && in_window;
    assign rd_addr   = oidx;

    // R7: a compute cycle is never spent on a zero tap.
    assert_mac_nonzero_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MAC) |-> nz_mask[kidx]);

    // R10: the engine reopens right after the last output handshake.
    assert_reopen_R10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && (oidx == AW'(NOUT - 1))) |=> in_ready);

endmodule

// File: rtl/dcu_accum.sv
module dcu_accum
    import deconv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 16,
    parameter int NOUT   = 16,
    localparam int AW    = cbits(NOUT),
    localparam int PW    = 2 * DATA_W,
    localparam int EW    = PW + 1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              bias_load,
    input  logic [DATA_W-1:0] bias,
    input  logic              mac_fire,
    input  logic [AW-1:0]     acc_addr,
    input  logic [DATA_W-1:0] w_data,
    input  logic [DATA_W-1:0] x_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] acc_q [NOUT];

    logic signed [PW-1:0] prod, scaled;
    logic [DATA_W-1:0]    cur;
    logic [EW-1:0]        wide;
    logic [EW-DATA_W:0]   top;
    logic                 fits;
    logic [DATA_W-1:0]    sum_sat;

    always_comb begin
        prod    = $signed(w_data) * $signed(x_data);
        scaled  = prod >>> FRAC_W;
        cur     = acc_q[acc_addr];
        wide    = {{(EW - DATA_W){cur[DATA_W-1]}}, cur} + {scaled[PW-1], scaled};
        top     = wide[EW-1:DATA_W-1];
        fits    = (&top) || (~|top);
        if (fits) begin
            sum_sat = wide[DATA_W-1:0];
        end else if (wide[EW-1]) begin
            sum_sat = {1'b1, {(DATA_W - 1){1'b0}}};
        end else begin
            sum_sat = {1'b0, {(DATA_W - 1){1'b1}}};
        end
    end

    for (genvar g = 0; g < NOUT; g++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[g] <= '0;
            end else if (bias_load) begin
                acc_q[g] <= bias;
            end else if (mac_fire && (acc_addr == AW'(g))) begin
                acc_q[g] <= sum_sat;
            end
        end
    end

    assign rd_data = acc_q[rd_addr];

    // R6: adding two non-negative terms never wraps to a negative result.
    assert_no_wrap_pos_R6: assert property (@(posedge clk) disable iff (rst)
        (mac_fire && !cur[DATA_W-1] && !prod[PW-1]) |-> !sum_sat[DATA_W-1]);

    // R6: adding two negative terms never wraps to a non-negative result.
    assert_no_wrap_neg_R6: assert property (@(posedge clk) disable iff (rst)
        (mac_fire && cur[DATA_W-1] && scaled[PW-1]) |-> sum_sat[DATA_W-1]);

endmodule

// File: rtl/deconv_cu.sv
module deconv_cu
    import deconv_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int FRAC_W = 16,
    parameter int KSZ    = 3,
    parameter int STRIDE = 2,
    parameter int PAD    = 1,
    parameter int TOUT   = 4,
    parameter int NCH    = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int TIN  = patch_dim(TOUT, KSZ, STRIDE);
    localparam int NIN  = TIN * TIN;
    localparam int NW   = KSZ * KSZ;
    localparam int NOUT = TOUT * TOUT;
    localparam int LW   = cbits(NIN + NW);
    localparam int IAW  = cbits(NIN);
    localparam int WAW  = cbits(NW);
    localparam int AW   = cbits(NOUT);

    logic              bias_load, ld_en, mac_fire;
    logic [LW-1:0]     ld_addr;
    logic [WAW-1:0]    w_sel;
    logic [IAW-1:0]    x_addr;
    logic [AW-1:0]     acc_addr, rd_addr;
    logic [NW-1:0]     nz_mask;
    logic [DATA_W-1:0] x_data, w_data;

    dcu_loop_ctrl #(
        .KSZ(KSZ), .STRIDE(STRIDE), .PAD(PAD), .TOUT(TOUT), .NCH(NCH)
    ) ctrl_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready),
        .out_valid(out_valid), .out_ready(out_ready),
        .nz_mask(nz_mask),
        .bias_load(bias_load), .ld_en(ld_en), .ld_addr(ld_addr),
        .w_sel(w_sel), .x_addr(x_addr),
        .mac_fire(mac_fire), .acc_addr(acc_addr), .rd_addr(rd_addr)
    );

    dcu_tile_store #(
        .DATA_W(DATA_W), .NIN(NIN), .NW(NW)
    ) store_i (
        .clk(clk), .rst(rst),
        .wr_en(ld_en), .wr_addr(ld_addr), .wr_data(in_data),
        .x_addr(x_addr), .x_data(x_data),
        .w_sel(w_sel), .w_data(w_data),
        .nz_mask(nz_mask)
    );

    dcu_accum #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .NOUT(NOUT)
    ) accum_i (
        .clk(clk), .rst(rst),
        .bias_load(bias_load), .bias(in_data),
        .mac_fire(mac_fire), .acc_addr(acc_addr),
        .w_data(w_data), .x_data(x_data),
        .rd_addr(rd_addr), .rd_data(out_data)
    );

    // R9: a stalled output word holds until taken.
    assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/deconv_cu_tb_top.sv
`timescale 1ns/1ps
module deconv_cu_tb_top;

    localparam int DW    = 32;
    localparam int FRAC  = 16;
    localparam int KSZ   = 3;
    localparam int STR   = 2;
    localparam int PAD   = 1;
    localparam int TOUT  = 4;
    localparam int NCH   = 2;
    localparam int TIN   = 4;
    localparam int NIN   = TIN * TIN;
    localparam int NW    = KSZ * KSZ;
    localparam int NOUT  = TOUT * TOUT;
    localparam int STEPS = 2;
    localparam longint MAXV = 64'sh7FFF_FFFF;
    localparam longint MINV = -64'sh8000_0000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [DW-1:0] out_data;

    int checks = 0;
    int failures = 0;

    logic [DW-1:0] tb_bias;
    logic [DW-1:0] tb_x [NCH][NIN];
    logic [DW-1:0] tb_w [NCH][NW];
    longint exp_px [NOUT];

    always #2 clk = ~clk;

    deconv_cu dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Scatter-form reference: each patch pixel feeds oh = ih*S + kh - P.
    task automatic build_ref();
        for (int p = 0; p < NOUT; p++) exp_px[p] = longint'($signed(tb_bias));
        for (int c = 0; c < NCH; c++)
            for (int kh = 0; kh < KSZ; kh++)
                for (int kw = 0; kw < KSZ; kw++)
                    for (int ih = 0; ih < TIN; ih++)
                        for (int iw = 0; iw < TIN; iw++) begin
                            int oh = ih * STR + kh - PAD;
                            int ow = iw * STR + kw - PAD;
                            if (oh >= 0 && oh < TOUT && ow >= 0 && ow < TOUT) begin
                                longint pr = longint'($signed(tb_w[c][kh*KSZ+kw])) *
                                             longint'($signed(tb_x[c][ih*TIN+iw]));
                                longint s = exp_px[oh*TOUT+ow] + (pr >>> FRAC);
                                if (s > MAXV) s = MAXV;
                                if (s < MINV) s = MINV;
                                exp_px[oh*TOUT+ow] = s;
                            end
                        end
    endtask

    function automatic int nnz(input int c);
        int n = 0;
        for (int j = 0; j < NW; j++) if (tb_w[c][j] != '0) n++;
        return n;
    endfunction

    task automatic beat(input logic [DW-1:0] d);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
    endtask

    // R2 framing; returns the in_ready-low cycle count after channel 0 (R7).
    task automatic send_tile(output int gap0);
        gap0 = -1;
        beat(tb_bias);
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < NIN; i++) beat(tb_x[c][i]);
            for (int j = 0; j < NW; j++) beat(tb_w[c][j]);
            in_valid = 1'b0;
            if (c == 0) begin
                int n = 0;
                while (!in_ready) begin
                    n++;
                    @(negedge clk);
                end
                gap0 = n;
            end
        end
    endtask

    task automatic collect(input bit bp, input string req);
        int idx = 0;
        int cyc = 0;
        logic [DW-1:0] held = '0;
        bit pend = 1'b0;
        in_valid = 1'b1;
        in_data  = 32'h0BAD_F00D;
        while (idx < NOUT && cyc < 2000) begin
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            if (pend) chk(out_valid && out_data == held, "R9 hold under stall",
                          longint'($signed(out_data)), longint'($signed(held)));
            pend = 1'b0;
            if (out_valid) begin
                if (idx == 0) chk(in_ready == 1'b0, "R10 closed while draining", in_ready, 0);
                if (out_ready) begin
                    chk(longint'($signed(out_data)) == exp_px[idx],
                        $sformatf("%s pixel %0d", req, idx),
                        longint'($signed(out_data)), exp_px[idx]);
                    idx++;
                end else begin
                    held = out_data;
                    pend = 1'b1;
                end
            end
            cyc++;
            @(negedge clk);
        end
        out_ready = 1'b0;
        chk(idx == NOUT, "R9 word count", idx, NOUT);
        chk(in_ready == 1'b1, "R10 reopen after last word", in_ready, 1);
        in_valid = 1'b0;
    endtask

    task automatic run(input string req, input bit bp, input int exp_gap_check);
        int gap;
        build_ref();
        send_tile(gap);
        if (exp_gap_check != 0)
            chk(gap == 1 + STEPS * STEPS * nnz(0), "R7 compute cycles ch0",
                gap, 1 + STEPS * STEPS * nnz(0));
        collect(bp, req);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    endtask

    task automatic t_mixed();
        tb_bias = 32'h0001_8000;
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < NIN; i++) tb_x[c][i] = DW'(((i * 7 + c * 3) % 11 - 5) * 32768);
            for (int j = 0; j < NW; j++)  tb_w[c][j] = DW'(((j * 5 + c) % 7 - 3) * 16384);
        end
        run("R2 R4 mixed", 1'b0, 1);
    endtask

    task automatic t_bias_only();
        tb_bias = 32'h0003_0000;
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < NIN; i++) tb_x[c][i] = DW'((i + 1) * 65536);
            for (int j = 0; j < NW; j++)  tb_w[c][j] = '0;
        end
        run("R3 zero kernels", 1'b0, 1);
    endtask

    task automatic t_sparse();
        tb_bias = 32'hFFFF_0000;
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < NIN; i++) tb_x[c][i] = DW'((i - 6) * 65536 + c * 4096);
            for (int j = 0; j < NW; j++)  tb_w[c][j] = (j % 4 == 0) ? DW'((j + 1) * 8192 - c * 3000) : '0;
        end
        run("R4 R7 sparse", 1'b1, 1);
    endtask

    task automatic t_sat_pos();
        tb_bias = 32'h7FFF_0000;
        for (int i = 0; i < NIN; i++) begin
            tb_x[0][i] = DW'(100 * 65536);
            tb_x[1][i] = DW'(65536);
        end
        for (int j = 0; j < NW; j++) begin
            tb_w[0][j] = DW'(65536);
            tb_w[1][j] = DW'(-65536);
        end
        run("R6 R8 positive clamp", 1'b0, 0);
    endtask

    task automatic t_sat_neg();
        tb_bias = 32'h8001_0000;
        for (int i = 0; i < NIN; i++) begin
            tb_x[0][i] = DW'(-100 * 65536);
            tb_x[1][i] = DW'(-65536);
        end
        for (int j = 0; j < NW; j++) begin
            tb_w[0][j] = DW'(65536);
            tb_w[1][j] = DW'(-65536);
        end
        run("R6 R8 negative clamp", 1'b1, 0);
    endtask

    task automatic t_floor();
        tb_bias = '0;
        for (int i = 0; i < NIN; i++) begin
            tb_x[0][i] = DW'(1);
            tb_x[1][i] = DW'(1);
        end
        for (int j = 0; j < NW; j++) begin
            tb_w[0][j] = DW'(-1);
            tb_w[1][j] = DW'(1);
        end
        run("R5 floor rescale", 1'b0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_bias_only();
        t_sparse();
        t_sat_pos();
        t_sat_neg();
        t_floor();
        t_mixed();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule